// File: doc/BRIEF.md
# Triple-Voted Configuration Register Bank

This block holds the small set of configuration bits whose corruption would be most harmful: a global enable bit, a group of interrupt mask bits and a group of write protection enable bits. Each of these bits is kept in three copies. The value presented to the rest of the chip is the majority of the three copies, so a single upset copy is outvoted and the outputs stay correct. A wider mode field sits alongside them. It is kept as a single copy together with one even-parity bit that is captured when the field is written.

Software can flip copy 0 of any voted bit, or the stored mode parity bit, through a fault injection register. This lets the error reporting be exercised without disturbing the voted outputs. The block raises a flag for any copy disagreement, a flag for a parity mismatch and a flag while any injected fault is active. It also drives two summary flags built from these. Copies are written only by bus writes. Nothing in the block scrubs them.

Top module: `tmr_cfg_bank`

## Requirements
- R1: After reset, `enable`, `irq_mask`, `prot_en` and `mode` are all 0, and every error flag is 0.
- R2: A write to address 0 loads `wr_data[0]` into all three copies of the enable bit, and `enable` shows it in the cycle after the write edge.
- R3: A write to address 1 loads `wr_data[MASK_W-1:0]` into `irq_mask`. A write to address 2 loads `wr_data[PROT_W-1:0]` into `prot_en`.
- R4: A write to address 3 loads `wr_data[MODE_W-1:0]` into `mode` and stores the even parity of that value.
- R5: When copy 0 of a voted bit is inverted by injection, the voted output keeps the value last written.
- R6: Any disagreement among the three copies of any voted bit sets `vote_err`, and with it both `safety_err` and `seq_err`.
- R7: A mismatch between `mode` and its stored parity bit sets `parity_err`, `safety_err` and `seq_err`. Writing values with an even or an odd number of ones raises no error on its own.
- R8: `inject_active` and `safety_err` are 1 whenever the fault injection register is nonzero. With the register at zero, `vote_err`, `parity_err` and `inject_active` are all 0.
- R9: A normal write made while a fault is injected still loads all three copies. The voted output follows the new value, and the disagreement persists while the injection bit stays set.
- R10: A write to any address above 4 changes no output.
- R11: Writing address 4 loads the fault injection register. Bit 0 targets the enable bit. Bits 1 to MASK_W target the mask bits in order. The next PROT_W bits target the protection bits. The bit above those targets the stored mode parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0 ctrl, 1 mask, 2 protect, 3 mode, 4 injection |
| wr_data | input | DW | Write data |
| enable | output | 1 | Voted enable bit |
| irq_mask | output | MASK_W | Voted interrupt mask bits |
| prot_en | output | PROT_W | Voted write protection enable bits |
| mode | output | MODE_W | Mode field |
| vote_err | output | 1 | Copies of some voted bit disagree |
| parity_err | output | 1 | Mode parity mismatch |
| inject_active | output | 1 | Fault injection register is nonzero |
| seq_err | output | 1 | Vote or parity error |
| safety_err | output | 1 | Any error or an active injection |

## Verification
The bench injects faults into individual copies of 1 bits and of 0 bits. It checks that each voted output holds its value. A design that read a single copy, or voted on the wrong bit, would flip an output or fail to raise `vote_err`. It writes new values while an injection is held, which catches designs that write only the uninjected copies or that drop the disagreement. It flips only the parity bit, which catches a checker that inspects the data alone. Writes to unmapped addresses and to mode values of both parities expose decoders that alias addresses and parity checks that flag good data.

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank #(
  parameter int MASK_W = 4,
  parameter int PROT_W = 3,
  parameter int MODE_W = 8,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              enable,
  output logic [MASK_W-1:0] irq_mask,
  output logic [PROT_W-1:0] prot_en,
  output logic [MODE_W-1:0] mode,
  output logic              vote_err,
  output logic              parity_err,
  output logic              inject_active,
  output logic              seq_err,
  output logic              safety_err
);
  localparam int NP   = 1 + MASK_W + PROT_W;
  localparam int FIW  = NP + 1;
  localparam int M_LO = 1;
  localparam int P_LO = 1 + MASK_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_PROT = 3'd2,
                         A_MODE = 3'd3, A_FIR  = 3'd4;

  logic [NP-1:0]     c0, c1, c2, e0, voted, wval, wmask;
  logic [FIW-1:0]    fir;
  logic [MODE_W-1:0] mode_q;
  logic              par_q;
  logic              unused_hi;

  assign unused_hi = ^wr_data;

  always_comb begin
    wval  = '0;
    wmask = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin wval = NP'(wr_data[0]); wmask = NP'(1'b1); end
        A_MASK: begin
          wval  = NP'(wr_data[MASK_W-1:0]) << M_LO;
          wmask = NP'({MASK_W{1'b1}}) << M_LO;
        end
        A_PROT: begin
          wval  = NP'(wr_data[PROT_W-1:0]) << P_LO;
          wmask = NP'({PROT_W{1'b1}}) << P_LO;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; c2 <= '0;
      fir <= '0; mode_q <= '0; par_q <= 1'b0;
    end else begin
      c0 <= (c0 & ~wmask) | (wval & wmask);
      c1 <= (c1 & ~wmask) | (wval & wmask);
      c2 <= (c2 & ~wmask) | (wval & wmask);
      if (wr_en && wr_addr == A_MODE) begin
        mode_q <= wr_data[MODE_W-1:0];
        par_q  <= ^wr_data[MODE_W-1:0];
      end
      if (wr_en && wr_addr == A_FIR) fir <= wr_data[FIW-1:0];
    end
  end

  assign e0    = c0 ^ fir[NP-1:0];
  assign voted = (e0 & c1) | (e0 & c2) | (c1 & c2);

  assign enable        = voted[0];
  assign irq_mask      = voted[M_LO +: MASK_W];
  assign prot_en       = voted[P_LO +: PROT_W];
  assign mode          = mode_q;
  assign vote_err      = |((e0 ^ c1) | (c1 ^ c2));
  assign parity_err    = (^mode_q) ^ par_q ^ fir[NP];
  assign inject_active = |fir;
  assign seq_err       = vote_err | parity_err;
  assign safety_err    = seq_err | inject_active;

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CTRL |=> enable == $past(wr_data[0]));
  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_MODE |=> mode == $past(wr_data[MODE_W-1:0]));
  // R6
  vote_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_err |-> safety_err && seq_err);
  // R7
  parity_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> safety_err && seq_err);
  // R8
  inject_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_active |-> safety_err);
  // R8
  clean_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inject_active |-> !vote_err && !parity_err);
  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr > A_FIR |=> $stable(enable) && $stable(irq_mask)
                                 && $stable(prot_en) && $stable(mode));
endmodule

// File: tb/tmr_cfg_bank_tb_top.sv
module tmr_cfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        enable, vote_err, parity_err, inject_active, seq_err, safety_err;
  logic [3:0]  irq_mask;
  logic [2:0]  prot_en;
  logic [7:0]  mode;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable(enable), .irq_mask(irq_mask), .prot_en(prot_en), .mode(mode),
    .vote_err(vote_err), .parity_err(parity_err), .inject_active(inject_active),
    .seq_err(seq_err), .safety_err(safety_err));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_flags(input string tag, input logic v, input logic p, input logic i);
    chk({tag, " vote_err"}, 16'(vote_err), 16'(v));
    chk({tag, " parity_err"}, 16'(parity_err), 16'(p));
    chk({tag, " inject_active"}, 16'(inject_active), 16'(i));
    chk({tag, " seq_err"}, 16'(seq_err), 16'(v | p));
    chk({tag, " safety_err"}, 16'(safety_err), 16'(v | p | i));
  endtask

  task automatic t_reset;
    chk("R1 enable", 16'(enable), 16'h0);
    chk("R1 irq_mask", 16'(irq_mask), 16'h0);
    chk("R1 prot_en", 16'(prot_en), 16'h0);
    chk("R1 mode", 16'(mode), 16'h0);
    chk_flags("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_basic;
    wr(3'd0, 16'hFFF1); chk("R2 enable set", 16'(enable), 16'h1);
    wr(3'd1, 16'h00FA); chk("R3 irq_mask", 16'(irq_mask), 16'hA);
    wr(3'd2, 16'h00FD); chk("R3 prot_en", 16'(prot_en), 16'h5);
    wr(3'd3, 16'h0001); chk("R4 mode odd", 16'(mode), 16'h01);
    chk_flags("R7 odd value", 1'b0, 1'b0, 1'b0);
    wr(3'd3, 16'h0096); chk("R4 mode even", 16'(mode), 16'h96);
    chk_flags("R7 even value", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_unmapped;
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 16'hFFFF);
      chk("R10 enable", 16'(enable), 16'h1);
      chk("R10 irq_mask", 16'(irq_mask), 16'hA);
      chk("R10 prot_en", 16'(prot_en), 16'h5);
      chk("R10 mode", 16'(mode), 16'h96);
      chk_flags("R10", 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_inject_vote;
    wr(3'd4, 16'h0001);
    chk("R5 enable held", 16'(enable), 16'h1);
    chk_flags("R6 enable copy", 1'b1, 1'b0, 1'b1);
    wr(3'd4, 16'h0004);
    chk("R11 mask bit1 held", 16'(irq_mask), 16'hA);
    chk_flags("R6 mask copy", 1'b1, 1'b0, 1'b1);
    wr(3'd4, 16'h0040);
    chk("R11 prot bit1 held", 16'(prot_en), 16'h5);
    chk("R11 mask untouched", 16'(irq_mask), 16'hA);
    chk_flags("R6 prot zero copy", 1'b1, 1'b0, 1'b1);
    wr(3'd4, 16'h00FF);
    chk("R5 all enable", 16'(enable), 16'h1);
    chk("R5 all mask", 16'(irq_mask), 16'hA);
    chk("R5 all prot", 16'(prot_en), 16'h5);
    chk_flags("R6 all copies", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_write_under_fault;
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0000);
    chk("R9 enable follows 0", 16'(enable), 16'h0);
    chk_flags("R9 fault persists", 1'b1, 1'b0, 1'b1);
    wr(3'd0, 16'h0001);
    chk("R9 enable follows 1", 16'(enable), 16'h1);
    wr(3'd4, 16'h0000);
    chk("R9 enable after clear", 16'(enable), 16'h1);
    chk_flags("R8 cleared", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_parity;
    wr(3'd4, 16'h0100);
    chk("R7 mode held", 16'(mode), 16'h96);
    chk_flags("R7 parity flip", 1'b0, 1'b1, 1'b1);
    wr(3'd3, 16'h0007);
    chk("R7 mode rewritten", 16'(mode), 16'h07);
    chk_flags("R7 flip persists", 1'b0, 1'b1, 1'b1);
    wr(3'd4, 16'h0000);
    chk_flags("R8 parity cleared", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_unmapped();
    t_inject_vote();
    t_write_under_fault();
    t_parity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule